// File: doc/BRIEF.md
# Iterative Comparator Response Analyzer

This block checks the outputs of pairs of identical units under self-test. The units receive the same stimulus, and a fault-free pair gives equal outputs, so no golden response is stored or regenerated. Each comparator stage takes one pair of output vectors and raises a local mismatch when they differ. That mismatch is ORed into a mismatch line that ripples from stage 0 to the last stage. The end of the line feeds a sticky error flop.

When the error flop sets, it also stores the lowest-numbered failing stage for diagnosis. It feeds back to gate every stage, so no later comparison can change the result. A test controller raises the enable for the test window and pulses clear before a new phase. When the window has closed, it reads pass/fail and the failing stage index.

Top module: `resp_cmp_chain`

## Requirements
- R1: While reset is held, and after reset with enable low, fail_o is 0, fail_idx_o is 0 and pass_o is 1.
- R2: While enable_i is high and every stage pair is equal, fail_o stays 0.
- R3: With enable_i high and no error latched, a difference in any bit of any stage pair sets fail_o on the next rising clock edge. Stage k occupies bits [k*VEC_W +: VEC_W] of both unit buses.
- R4: While enable_i is low, differing stage pairs do not set fail_o.
- R5: Once set, fail_o stays 1 until clear_i, whatever the unit inputs or the enable do.
- R6: In the cycle where fail_o sets, fail_idx_o takes the lowest stage number whose pair differs.
- R7: After an error is latched, later mismatches in any stage, including lower-numbered ones, leave fail_idx_o unchanged.
- R8: clear_i high at a rising edge returns fail_o and fail_idx_o to 0. Clear wins over a mismatch in the same cycle.
- R9: pass_o is 1 exactly when enable_i is low and fail_o is 0. It is therefore 0 throughout the test window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous clear of the error flop and index |
| enable_i | input | 1 | High during the test window |
| unit_a_i | input | NUM_STAGES*VEC_W | Outputs of the first unit of each pair, stage 0 in the low bits |
| unit_b_i | input | NUM_STAGES*VEC_W | Outputs of the second unit of each pair, same layout |
| fail_o | output | 1 | Sticky error flag |
| pass_o | output | 1 | Pass result, valid once enable is low |
| fail_idx_o | output | max(1,clog2(NUM_STAGES)) | Lowest failing stage at the moment the error latched |

## Verification
The bench builds the block with NUM_STAGES = 5 and VEC_W = 16. Five stages is not a power of two, so the 3-bit index has codes that must never appear. The last stage, index 4, sits at the top of an 80-bit bus, where a slicing error would show. Single-bit flips at both ends of a 16-bit word are used, and so is a mismatch in two stages at once, which tests the lowest-index priority.

// File: rtl/resp_cmp_pkg.sv
package resp_cmp_pkg;
  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/cmp_stage.sv
module cmp_stage #(
  parameter int VEC_W = 16
) (
  input  logic [VEC_W-1:0] a_i,
  input  logic [VEC_W-1:0] b_i,
  input  logic             cmp_en_i,
  input  logic             prev_mm_i,
  output logic             local_mm_o,
  output logic             mm_o
);
  assign local_mm_o = cmp_en_i & (a_i != b_i);
  assign mm_o       = local_mm_o | prev_mm_i;
endmodule

// File: rtl/low_idx_enc.sv
module low_idx_enc #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]     req_i,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/err_capture.sv
module err_capture #(
  parameter int IDX_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             set_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic             err_o,
  output logic [IDX_W-1:0] idx_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_o <= 1'b0;
      idx_o <= '0;
    end else if (clear_i) begin
      err_o <= 1'b0;
      idx_o <= '0;
    end else if (set_i && !err_o) begin
      err_o <= 1'b1;
      idx_o <= idx_i;
    end
  end
endmodule

// File: rtl/resp_cmp_chain.sv
module resp_cmp_chain
  import resp_cmp_pkg::*;
#(
  parameter int NUM_STAGES = 4,
  parameter int VEC_W      = 16,
  localparam int IDX_W     = idx_width(NUM_STAGES),
  localparam int BUS_W     = NUM_STAGES * VEC_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             enable_i,
  input  logic [BUS_W-1:0] unit_a_i,
  input  logic [BUS_W-1:0] unit_b_i,
  output logic             fail_o,
  output logic             pass_o,
  output logic [IDX_W-1:0] fail_idx_o
);
  logic                  err_q;
  logic                  cmp_en;
  logic [NUM_STAGES:0]   mm_chain;
  logic [NUM_STAGES-1:0] local_mm;
  logic [IDX_W-1:0]      low_idx;

  // latched error freezes every comparator
  assign cmp_en      = enable_i & ~err_q;
  assign mm_chain[0] = 1'b0;

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
    cmp_stage #(.VEC_W(VEC_W)) u_stage (
      .a_i       (unit_a_i[s*VEC_W +: VEC_W]),
      .b_i       (unit_b_i[s*VEC_W +: VEC_W]),
      .cmp_en_i  (cmp_en),
      .prev_mm_i (mm_chain[s]),
      .local_mm_o(local_mm[s]),
      .mm_o      (mm_chain[s+1])
    );
  end

  low_idx_enc #(.N(NUM_STAGES), .IDX_W(IDX_W)) u_enc (
    .req_i(local_mm),
    .idx_o(low_idx)
  );

  err_capture #(.IDX_W(IDX_W)) u_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(clear_i),
    .set_i  (mm_chain[NUM_STAGES]),
    .idx_i  (low_idx),
    .err_o  (err_q),
    .idx_o  (fail_idx_o)
  );

  assign fail_o = err_q;
  assign pass_o = ~err_q & ~enable_i;
endmodule

// File: rtl/resp_cmp_chain_chk.sv
module resp_cmp_chain_chk #(
  parameter int NUM_STAGES = 4,
  parameter int VEC_W      = 16,
  parameter int IDX_W      = 2
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        clear_i,
  input logic                        enable_i,
  input logic [NUM_STAGES*VEC_W-1:0] unit_a_i,
  input logic [NUM_STAGES*VEC_W-1:0] unit_b_i,
  input logic                        fail_o,
  input logic                        pass_o,
  input logic [IDX_W-1:0]            fail_idx_o
);
  // R3
  mismatch_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i && !fail_o && !clear_i && (unit_a_i != unit_b_i) |=> fail_o);
  // R4
  idle_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i && !fail_o && !clear_i |=> !fail_o);
  // R5
  sticky_fail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o && !clear_i |=> fail_o);
  // R7
  idx_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o && !clear_i |=> $stable(fail_idx_o));
  // R8
  clear_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !fail_o && fail_idx_o == '0);
  // R9
  no_pass_in_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i |-> !pass_o);
endmodule

bind resp_cmp_chain resp_cmp_chain_chk #(
  .NUM_STAGES(NUM_STAGES), .VEC_W(VEC_W), .IDX_W(IDX_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear_i), .enable_i(enable_i),
  .unit_a_i(unit_a_i), .unit_b_i(unit_b_i), .fail_o(fail_o),
  .pass_o(pass_o), .fail_idx_o(fail_idx_o)
);

// File: tb/resp_cmp_chain_test.sv
module resp_cmp_chain_test;
  localparam int NS  = 5;
  localparam int VW  = 16;
  localparam int BW  = NS * VW;
  localparam int IW  = 3;

  typedef struct {
    logic           f;
    logic [IW-1:0]  i;
    logic           p;
    string          tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clear = 1'b0;
  logic en = 1'b0;
  logic [BW-1:0] ua = '0;
  logic [BW-1:0] ub = '0;
  logic fail, pass;
  logic [IW-1:0] fidx;

  int tests = 0;
  int errs = 0;
  bit done = 0;
  exp_t q[$];

  logic          m_fail = 1'b0;
  logic [IW-1:0] m_idx  = '0;

  always #5 clk = ~clk;

  resp_cmp_chain #(.NUM_STAGES(NS), .VEC_W(VW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clear), .enable_i(en),
    .unit_a_i(ua), .unit_b_i(ub), .fail_o(fail), .pass_o(pass),
    .fail_idx_o(fidx)
  );

  task automatic chk(input string tag, input logic [IW:0] act, input logic [IW:0] expv);
    tests++;
    if (act !== expv) begin
      errs++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, expv);
    end
  endtask

  // driver: applies one cycle of stimulus and queues the expected result
  task automatic drive(input logic c, input logic e, input logic [BW-1:0] a,
                       input logic [BW-1:0] b, input string tag);
    exp_t x;
    @(negedge clk);
    clear = c; en = e; ua = a; ub = b;
    if (c) begin
      m_fail = 1'b0; m_idx = '0;
    end else if (e && !m_fail) begin
      for (int s = NS - 1; s >= 0; s--) begin
        if (a[s*VW +: VW] != b[s*VW +: VW]) begin
          m_fail = 1'b1; m_idx = IW'(s);
        end
      end
    end
    x.f = m_fail; x.i = m_idx; x.p = !m_fail && !e; x.tag = tag;
    q.push_back(x);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t x;
        x = q.pop_front();
        chk({x.tag, " fail"}, {{IW{1'b0}}, fail}, {{IW{1'b0}}, x.f});
        chk({x.tag, " idx"},  {1'b0, fidx},       {1'b0, x.i});
        chk({x.tag, " pass"}, {{IW{1'b0}}, pass}, {{IW{1'b0}}, x.p});
      end
    end
  end

  function automatic logic [BW-1:0] flip(input logic [BW-1:0] v, input int stage, input int bitn);
    logic [BW-1:0] r;
    r = v;
    r[stage*VW + bitn] = ~r[stage*VW + bitn];
    return r;
  endfunction

  initial begin
    logic [BW-1:0] pat;
    #3;
    chk("R1 reset fail", {{IW{1'b0}}, fail}, '0);
    chk("R1 reset idx",  {1'b0, fidx}, '0);
    chk("R1 reset pass", {{IW{1'b0}}, pass}, {{IW{1'b0}}, 1'b1});
    @(negedge clk); rst_n = 1'b1;
    drive(0, 0, '0, '0, "R1 idle");
    // R2: equal patterns in window
    pat = {5{16'hA5C3}};
    drive(0, 1, pat, pat, "R2 eq1");
    drive(0, 1, ~pat, ~pat, "R2 eq2");
    drive(0, 1, {BW{1'b1}}, {BW{1'b1}}, "R2 eq3");
    // R4: mismatches with enable low
    drive(0, 0, pat, ~pat, "R4 idle mm");
    drive(0, 0, flip(pat, 2, 7), pat, "R4 idle mm2");
    // R3/R6: two stages differ, lowest wins
    drive(0, 1, flip(flip(pat, 3, 0), 1, 9), pat, "R3 R6 two stages");
    // R7/R5: later lower-stage mismatch, no change
    drive(0, 1, flip(pat, 0, 4), pat, "R7 later low mm");
    drive(0, 1, pat, pat, "R5 equal after err");
    drive(0, 0, pat, pat, "R5 R9 window closed");
    // R8: clear beats simultaneous mismatch
    drive(1, 1, flip(pat, 2, 3), pat, "R8 clear vs mm");
    drive(0, 1, pat, pat, "R8 after clear");
    // R3/R6: top bit of last stage
    drive(0, 1, flip(pat, 4, 15), pat, "R3 R6 last stage msb");
    drive(0, 0, '0, '0, "R9 pass low on fail");
    drive(1, 0, '0, '0, "R8 clear idle");
    drive(0, 1, flip('0, 0, 0), '0, "R6 stage0 bit0");
    drive(0, 1, flip('0, 4, 15), flip('0, 4, 14), "R7 stage4 ignored");
    drive(1, 0, '0, '0, "R8 clear");
    drive(0, 0, '0, '0, "R9 pass");
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, errs);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      tests++; errs++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, errs);
      $finish;
    end
  end
endmodule